// File: doc/BRIEF.md
# Single-Cycle Load/Store Core with Indexed Memory Access

This block is a 32-bit load/store processor core. Every instruction completes in a single clock cycle. The core has 32 general registers and two internal word memories, one for instructions and one for data. The base instructions cover:

- register-register addition;
- add, subtract and shift-left with a literal;
- word loads and stores;
- branches on zero and on nonzero, each writing a return link.

Five extensions sit on top of the base set:

- a load and a store that add two registers to form the address;
- a move-if-zero, in register form and in literal form;
- an exchange of one register with one memory word.

The register file has three read ports, one for each register field. This lets the indexed store read base, index and data in the same cycle. A conditional move sets its register write enable straight from a zero test on the first source register.

Before a program runs, both memories are loaded through a word-wide preload port while reset is held. After execution, the register file and the data memory can be read through two combinational observation ports.

Top module: `idx_core`

## Requirements
- R1: Instruction word fields are opcode [31:26], Rc [25:21], Ra [20:16], Rb [15:11] and literal [15:0]. Opcodes are: ADD 0x20, ADDC 0x30, SUBC 0x31, SHLC 0x3C, LD 0x18, ST 0x19, BEQ 0x1C, BNE 0x1D, LDX 0x10, STX 0x11, MVZ 0x12, MVZC 0x13, MSWP 0x14. Any instruction that is not a branch moves PC to PC+4.
- R2: While rst_ni is low, PC is 0 and every register reads 0.
- R3: ADD writes Ra+Rb into Rc. ADDC, SUBC and SHLC write Ra+lit, Ra-lit and Ra<<lit[4:0] into Rc, where lit is the sign-extended 16-bit literal.
- R4: In literal-form instructions the B operand is the literal itself. Bits [15:11] are never used as a register address.
- R5: Register 31 always reads 0, and any write to it is discarded.
- R6: LD(Ra,lit,Rc) loads Mem[Ra+lit] into Rc. ST(Rc,lit,Ra) stores Rc into Mem[Ra+lit]. Addresses are byte addresses, the low two bits are ignored, and a store takes effect at the clock edge.
- R7: LDX loads Mem[Ra+Rb] into Rc in one cycle.
- R8: STX stores Rc into Mem[Ra+Rb] in one cycle, and all other data words are left unchanged.
- R9: BEQ and BNE always write PC+4 into Rc. BEQ branches when Ra is zero, and BNE branches when Ra is nonzero. The branch target is PC+4+4*lit. An unconditional branch is BEQ with Ra=31.
- R10: MVZ writes Rb into Rc, and MVZC writes lit into Rc, only when Ra is zero. Otherwise Rc is unchanged.
- R11: MSWP(Ra,lit,Rc) writes the old Mem[Ra+lit] into Rc and the old Rc into that memory word, both in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of PC and registers |
| ld_we_i | input | 1 | Preload write strobe |
| ld_dmem_i | input | 1 | Preload target: 1 selects data memory, 0 selects instruction memory |
| ld_addr_i | input | 6 | Preload word index |
| ld_data_i | input | 32 | Preload word |
| dbg_reg_i | input | 5 | Register number to observe |
| dbg_reg_o | output | 32 | Value of the observed register |
| dbg_mem_i | input | 6 | Data memory word index to observe |
| dbg_mem_o | output | 32 | Value of the observed data word |
| pc_o | output | 32 | Current program counter |

## Verification
Each instruction's register write, memory write and PC update are all due at the first rising edge after it is fetched. A program of N instructions has therefore finished after N edges. Every program ends in a self-branch that changes only register 31. The bench releases reset at a falling edge and lets a few more cycles pass than the program length. It then reads registers and data words through the combinational observation ports between edges, when the state can no longer move. The reset state is checked while reset is still asserted, after the memories have been preloaded.

// File: rtl/idx_core_pkg.sv
package idx_core_pkg;
  typedef enum logic [5:0] {
    OP_LDX  = 6'h10, OP_STX  = 6'h11, OP_MVZ  = 6'h12, OP_MVZC = 6'h13,
    OP_MSWP = 6'h14, OP_LD   = 6'h18, OP_ST   = 6'h19, OP_BEQ  = 6'h1C,
    OP_BNE  = 6'h1D, OP_ADD  = 6'h20, OP_ADDC = 6'h30, OP_SUBC = 6'h31,
    OP_SHLC = 6'h3C
  } opcode_e;

  typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SHL, ALU_PASSB} alu_op_e;
  typedef enum logic [1:0] {WD_ALU, WD_MEM, WD_LINK} wd_sel_e;

  typedef struct packed {
    alu_op_e alu_op;
    logic    b_lit;
    wd_sel_e wd_sel;
    logic    rf_we;
    logic    mem_we;
    logic    br_eq;
    logic    br_ne;
  } ctrl_t;
endpackage

// File: rtl/idx_regfile.sv
module idx_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] ra_addr_i,
  input  logic [AW-1:0] rb_addr_i,
  input  logic [AW-1:0] rc_addr_i,
  output logic [DW-1:0] ra_data_o,
  output logic [DW-1:0] rb_data_o,
  output logic [DW-1:0] rc_data_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [DW-1:0] wd_i,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [DW-1:0] dbg_data_o
);
  localparam logic [AW-1:0] ZREG = AW'(NREG - 1);

  logic [DW-1:0] regs [NREG];

  function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
    return (a == ZREG) ? '0 : regs[a];
  endfunction

  assign ra_data_o  = rd(ra_addr_i);
  assign rb_data_o  = rd(rb_addr_i);
  assign rc_data_o  = rd(rc_addr_i);
  assign dbg_data_o = rd(dbg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we_i && wa_i != ZREG) begin
      regs[wa_i] <= wd_i;
    end
  end

  // R5
  zero_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && wa_i == ZREG) |=> (dbg_addr_i != ZREG || dbg_data_o == '0));
endmodule

// File: rtl/idx_decode.sv
module idx_decode import idx_core_pkg::*; (
  input  logic [5:0] opcode_i,
  input  logic       ra_zero_i,
  output ctrl_t      ctrl_o
);
  always_comb begin
    ctrl_o = '0;
    case (opcode_i)
      OP_ADD:  ctrl_o.rf_we = 1'b1;
      OP_ADDC: begin ctrl_o.b_lit = 1'b1; ctrl_o.rf_we = 1'b1; end
      OP_SUBC: begin ctrl_o.alu_op = ALU_SUB; ctrl_o.b_lit = 1'b1; ctrl_o.rf_we = 1'b1; end
      OP_SHLC: begin ctrl_o.alu_op = ALU_SHL; ctrl_o.b_lit = 1'b1; ctrl_o.rf_we = 1'b1; end
      OP_LD:   begin ctrl_o.b_lit = 1'b1; ctrl_o.wd_sel = WD_MEM; ctrl_o.rf_we = 1'b1; end
      OP_ST:   begin ctrl_o.b_lit = 1'b1; ctrl_o.mem_we = 1'b1; end
      OP_BEQ:  begin ctrl_o.wd_sel = WD_LINK; ctrl_o.rf_we = 1'b1; ctrl_o.br_eq = 1'b1; end
      OP_BNE:  begin ctrl_o.wd_sel = WD_LINK; ctrl_o.rf_we = 1'b1; ctrl_o.br_ne = 1'b1; end
      OP_LDX:  begin ctrl_o.wd_sel = WD_MEM; ctrl_o.rf_we = 1'b1; end
      OP_STX:  ctrl_o.mem_we = 1'b1;
      OP_MVZ:  begin ctrl_o.alu_op = ALU_PASSB; ctrl_o.rf_we = ra_zero_i; end
      OP_MVZC: begin ctrl_o.alu_op = ALU_PASSB; ctrl_o.b_lit = 1'b1; ctrl_o.rf_we = ra_zero_i; end
      OP_MSWP: begin
        ctrl_o.b_lit  = 1'b1;
        ctrl_o.wd_sel = WD_MEM;
        ctrl_o.rf_we  = 1'b1;
        ctrl_o.mem_we = 1'b1;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/idx_alu.sv
module idx_alu import idx_core_pkg::*; #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  alu_op_e       op_i,
  output logic [DW-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_SUB:   y_o = a_i - b_i;
      ALU_SHL:   y_o = a_i << b_i[4:0];
      ALU_PASSB: y_o = b_i;
      default:   y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/idx_core.sv
module idx_core import idx_core_pkg::*; #(
  parameter int MEM_WORDS = 64,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_we_i,
  input  logic          ld_dmem_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [31:0]   ld_data_i,
  input  logic [4:0]    dbg_reg_i,
  output logic [31:0]   dbg_reg_o,
  input  logic [AW-1:0] dbg_mem_i,
  output logic [31:0]   dbg_mem_o,
  output logic [31:0]   pc_o
);
  localparam int DW = 32;
  localparam int NREG = 32;

  logic [DW-1:0] imem [MEM_WORDS];
  logic [DW-1:0] dmem [MEM_WORDS];
  logic [DW-1:0] pc_q, pc_plus4, pc_next, instr;
  logic [DW-1:0] ra_data, rb_data, rc_data, lit_sext, b_opnd, alu_y, mem_rd, rf_wd;
  logic [5:0]    opcode;
  logic [4:0]    rc_f, ra_f, rb_f;
  logic [AW-1:0] didx;
  logic          ra_zero, taken, mem_we_core;
  ctrl_t         ctrl;

  assign instr    = imem[pc_q[AW+1:2]];
  assign opcode   = instr[31:26];
  assign rc_f     = instr[25:21];
  assign ra_f     = instr[20:16];
  assign rb_f     = instr[15:11];
  assign lit_sext = {{16{instr[15]}}, instr[15:0]};

  idx_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk_i, .rst_ni,
    .ra_addr_i(ra_f), .rb_addr_i(rb_f), .rc_addr_i(rc_f),
    .ra_data_o(ra_data), .rb_data_o(rb_data), .rc_data_o(rc_data),
    .we_i(ctrl.rf_we), .wa_i(rc_f), .wd_i(rf_wd),
    .dbg_addr_i(dbg_reg_i), .dbg_data_o(dbg_reg_o)
  );

  assign ra_zero = (ra_data == '0);

  idx_decode u_dec (.opcode_i(opcode), .ra_zero_i(ra_zero), .ctrl_o(ctrl));

  assign b_opnd = ctrl.b_lit ? lit_sext : rb_data;

  idx_alu #(.DW(DW)) u_alu (.a_i(ra_data), .b_i(b_opnd), .op_i(ctrl.alu_op), .y_o(alu_y));

  assign didx        = alu_y[AW+1:2];
  assign mem_rd      = dmem[didx];
  assign mem_we_core = ctrl.mem_we & rst_ni;
  assign pc_plus4    = pc_q + 32'd4;

  always_comb begin
    case (ctrl.wd_sel)
      WD_MEM:  rf_wd = mem_rd;
      WD_LINK: rf_wd = pc_plus4;
      default: rf_wd = alu_y;
    endcase
  end

  assign taken   = (ctrl.br_eq & ra_zero) | (ctrl.br_ne & ~ra_zero);
  assign pc_next = taken ? pc_plus4 + {lit_sext[29:0], 2'b00} : pc_plus4;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_next;
  end

  always_ff @(posedge clk_i) begin
    if (ld_we_i && !ld_dmem_i) imem[ld_addr_i] <= ld_data_i;
  end

  always_ff @(posedge clk_i) begin
    if (ld_we_i && ld_dmem_i) dmem[ld_addr_i] <= ld_data_i;
    else if (mem_we_core)     dmem[didx]      <= rc_data;
  end

  assign dbg_mem_o = dmem[dbg_mem_i];
  assign pc_o      = pc_q;

  // R1
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl.br_eq || ctrl.br_ne) |=> pc_q == $past(pc_q) + 32'd4);
  // R9
  br_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken |=> pc_q == $past(pc_q) + 32'd4 + {$past(lit_sext[29:0]), 2'b00});
  // R10
  mvz_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode == OP_MVZ || opcode == OP_MVZC) |-> ctrl.rf_we == (ra_data == '0));
  // R8
  stx_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode == OP_STX && !ld_we_i) |=> dmem[$past(didx)] == $past(rc_data));
  // R11
  mswp_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opcode == OP_MSWP && !ld_we_i) |=> dmem[$past(didx)] == $past(rc_data));
endmodule

// File: tb/sim_idx_core.sv
`timescale 1ns/1ps
module sim_idx_core;
  localparam int MW = 64;
  localparam int AW = 6;
  localparam logic [5:0] LDX = 6'h10, STX = 6'h11, MVZ = 6'h12, MVZC = 6'h13, MSWP = 6'h14,
    LD = 6'h18, ST = 6'h19, BEQ = 6'h1C, BNE = 6'h1D, ADD = 6'h20, ADDC = 6'h30,
    SUBC = 6'h31, SHLC = 6'h3C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, ld_we = 1'b0, ld_dmem = 1'b0;
  logic [AW-1:0] ld_addr = '0, dbg_mem = '0;
  logic [31:0] ld_data = '0;
  logic [4:0] dbg_reg = '0;
  logic [31:0] dbg_reg_o, dbg_mem_o, pc;
  logic [31:0] prog [MW];
  logic [31:0] dinit [MW];
  int checks = 0, fails = 0;
  bit done = 0;

  idx_core #(.MEM_WORDS(MW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ld_we_i(ld_we), .ld_dmem_i(ld_dmem),
    .ld_addr_i(ld_addr), .ld_data_i(ld_data), .dbg_reg_i(dbg_reg),
    .dbg_reg_o(dbg_reg_o), .dbg_mem_i(dbg_mem), .dbg_mem_o(dbg_mem_o), .pc_o(pc)
  );

  function automatic logic [31:0] enc(input logic [5:0] op, input int rc, input int ra,
                                      input logic [15:0] lit);
    return {op, rc[4:0], ra[4:0], lit};
  endfunction
  function automatic logic [31:0] encr(input logic [5:0] op, input int rc, input int ra,
                                       input int rb);
    return {op, rc[4:0], ra[4:0], rb[4:0], 11'b0};
  endfunction
  function automatic logic [31:0] sx(input logic [15:0] l);
    return {{16{l[15]}}, l};
  endfunction

  localparam logic [31:0] HALT = {BEQ, 5'd31, 5'd31, 16'hFFFF};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rreg(input int r, output logic [31:0] v);
    dbg_reg = r[4:0];
    #1 v = dbg_reg_o;
  endtask

  task automatic rmem(input int w, output logic [31:0] v);
    dbg_mem = w[AW-1:0];
    #1 v = dbg_mem_o;
  endtask

  task automatic clear();
    for (int i = 0; i < MW; i++) begin prog[i] = HALT; dinit[i] = '0; end
  endtask

  task automatic run(input int n);
    logic [31:0] v;
    logic nz;
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 2 * MW; i++) begin
      ld_we = 1'b1; ld_dmem = (i >= MW); ld_addr = AW'(i % MW);
      ld_data = (i >= MW) ? dinit[i - MW] : prog[i];
      @(negedge clk);
    end
    ld_we = 1'b0;
    nz = 1'b0;
    for (int r = 0; r < 32; r++) begin rreg(r, v); if (v != 0) nz = 1'b1; end
    chk("R2 regs zero in reset", {31'b0, nz}, 32'd0);
    chk("R2 pc zero in reset", pc, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, e1, e2;
    logic [15:0] kv [7] = '{16'h0000, 16'h0001, 16'h0005, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h007B};
    logic [15:0] av [3] = '{16'h0000, 16'h0001, 16'hFFFE};
    logic [15:0] sv [3] = '{16'h0003, 16'hFFF0, 16'h0000};
    repeat (3) @(negedge clk);

    // R3 R4 R5: arithmetic sweep
    foreach (kv[n]) begin
      clear();
      prog[0] = enc(ADDC, 1, 31, kv[n]);
      prog[1] = enc(SUBC, 2, 1, 16'd3);
      prog[2] = enc(SHLC, 3, 1, 16'd4);
      prog[3] = encr(ADD, 4, 1, 2);
      prog[4] = enc(ADDC, 5, 1, 16'h0800);
      prog[5] = enc(ADDC, 31, 31, 16'd7);
      prog[6] = encr(ADD, 6, 31, 31);
      run(12);
      e1 = sx(kv[n]);
      rreg(1, v); chk("R3 ADDC", v, e1);
      rreg(2, v); chk("R3 SUBC", v, e1 - 32'd3);
      rreg(3, v); chk("R3 SHLC", v, e1 << 4);
      rreg(4, v); chk("R3 ADD", v, e1 + e1 - 32'd3);
      rreg(5, v); chk("R4 literal not register", v, e1 + 32'h800);
      rreg(6, v); chk("R5 r31 reads zero", v, 32'd0);
      rreg(31, v); chk("R5 r31 write discarded", v, 32'd0);
    end

    // R6 R7 R8: p[i] sweep over index
    for (int i = 0; i < 8; i++) begin
      clear();
      dinit[0] = 32'h40; dinit[1] = i;
      for (int j = 0; j < 8; j++) dinit[16 + j] = 1000 + 7 * j;
      prog[0] = enc(LD, 1, 31, 16'd0);
      prog[1] = enc(LD, 2, 31, 16'd4);
      prog[2] = enc(SHLC, 0, 2, 16'd2);
      prog[3] = encr(LDX, 3, 0, 1);
      prog[4] = enc(ADDC, 4, 3, 16'd1);
      prog[5] = encr(STX, 4, 1, 0);
      prog[6] = enc(ST, 4, 31, 16'd8);
      prog[7] = enc(LD, 5, 31, 16'd8);
      prog[8] = enc(LD, 7, 31, 16'd6);
      run(14);
      e1 = 1000 + 7 * i;
      rreg(3, v); chk("R7 LDX p[i]", v, e1);
      rmem(16 + i, v); chk("R8 STX target", v, e1 + 1);
      rmem(16 + (i + 1) % 8, v); chk("R8 STX neighbour", v, 1000 + 7 * ((i + 1) % 8));
      rmem(2, v); chk("R6 ST", v, e1 + 1);
      rreg(5, v); chk("R6 LD", v, e1 + 1);
      rreg(7, v); chk("R6 low bits ignored", v, i);
    end

    // R9: branches
    foreach (kv[n]) if (n < 4) begin
      clear();
      prog[0] = enc(ADDC, 1, 31, kv[n]);
      prog[1] = enc(BEQ, 2, 1, 16'd1);
      prog[2] = enc(ADDC, 10, 10, 16'd1);
      prog[3] = enc(BNE, 3, 1, 16'd1);
      prog[4] = enc(ADDC, 11, 11, 16'd1);
      prog[5] = enc(BEQ, 4, 31, 16'd1);
      prog[6] = enc(ADDC, 12, 12, 16'd1);
      run(12);
      rreg(2, v); chk("R9 BEQ link", v, 32'd8);
      rreg(3, v); chk("R9 BNE link", v, 32'd16);
      rreg(4, v); chk("R9 BR link", v, 32'd24);
      rreg(10, v); chk("R9 BEQ decision", v, (kv[n] != 0) ? 32'd1 : 32'd0);
      rreg(11, v); chk("R9 BNE decision", v, (kv[n] == 0) ? 32'd1 : 32'd0);
      rreg(12, v); chk("R9 BR skips", v, 32'd0);
      chk("R9 backward self-branch holds pc", pc, 32'd28);
    end

    // R10: conditional moves
    foreach (av[n]) begin
      clear();
      prog[0] = enc(ADDC, 1, 31, av[n]);
      prog[1] = enc(ADDC, 2, 31, 16'd77);
      prog[2] = enc(ADDC, 3, 31, 16'd11);
      prog[3] = encr(MVZ, 3, 1, 2);
      prog[4] = enc(ADDC, 4, 31, 16'd22);
      prog[5] = enc(MVZC, 4, 1, 16'hFFFB);
      prog[6] = encr(MVZ, 5, 31, 2);
      run(12);
      rreg(3, v); chk("R10 MVZ", v, (av[n] == 0) ? 32'd77 : 32'd11);
      rreg(4, v); chk("R10 MVZC", v, (av[n] == 0) ? 32'hFFFF_FFFB : 32'd22);
      rreg(5, v); chk("R10 MVZ on r31", v, 32'd77);
    end

    // R11: swap
    foreach (sv[n]) begin
      clear();
      e2 = 32'hCAFE_0000 | n;
      dinit[5] = e2;
      prog[0] = enc(ADDC, 1, 31, sv[n]);
      prog[1] = enc(ADDC, 2, 31, 16'd12);
      prog[2] = enc(MSWP, 1, 2, 16'd8);
      prog[3] = enc(LD, 3, 31, 16'd20);
      run(10);
      rreg(1, v); chk("R11 MSWP reg gets old mem", v, e2);
      rmem(5, v); chk("R11 MSWP mem gets old reg", v, sx(sv[n]));
      rreg(3, v); chk("R11 MSWP reload", v, sx(sv[n]));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule